// File: doc/BRIEF.md
# Clock-Monitor Interrupt Flag Controller

This block holds the interrupt enables and the sticky event flags of a clock and reset generator in two 8-bit registers on a simple register bus. It watches a periodic-timer timeout pulse and three status lines from the clock system: PLL lock, PLL tracking and self-clock mode. It turns changes on the lock and self-clock lines into flags that stay set until software clears them. The live status bits are readable next to the flags.

A dedicated active-low power-on input sits beside the ordinary reset. Power-on sets a flag that survives any later ordinary reset, so software can tell the two reset kinds apart. One interrupt line combines the three enabled event flags. The status lines are asynchronous to the block clock and pass through a two-stage synchronizer. The timeout pulse is taken as synchronous to the block clock.

Top module: `cm_irq_ctrl`

## Requirements
- R1: Address 0 is the enable register. Bit 7 enables the timeout interrupt, bit 4 the lock-change interrupt and bit 1 the self-clock-change interrupt. These bits are written directly, the other bits always read 0, and every reset clears the register.
- R2: Address 1 is the flag register, and its bit 5 always reads 0. Addresses 2 and 3 read as 0, and a write to them changes no register.
- R3: A high `tout_i` at a rising clock edge sets flag bit 7, which reads 1 right after that edge. Writing 1 to bit 7 clears it.
- R4: Flag bit 6 is the power-on flag. While `por_ni` is low, bit 6 is forced to 1 and every other register is cleared. While `rst_ni` is low, every register except bit 6 is cleared. Writing 1 to bit 6 clears it.
- R5: Flag bit 4 is set when the synchronized `lock_i` changes value, whether it rises or falls. The flag reads 1 after the third rising edge that follows a change of the input. Writing 1 to bit 4 clears it.
- R6: Flag bit 1 is set when the synchronized `scm_i` changes value in either direction, with the same three-edge timing as R5. Writing 1 to bit 1 clears it.
- R7: The live status bits are bit 0 (self-clock), bit 3 (lock) and bit 2 (tracking). Each follows its input two rising edges after the input changes. Bits 3 and 2 read 0 whenever the synchronized self-clock status is 1. The lock change in R5 is detected on the unmasked lock input.
- R8: `irq_o` is high exactly when at least one flag/enable pair is 1: bit 7 with enable bit 7, bit 4 with enable bit 4, or bit 1 with enable bit 1. The power-on flag never raises `irq_o`.
- R9: When a set event and a write-1-to-clear hit the same flag at the same edge, the flag ends up 1.
- R10: Writing 0 to a flag bit leaves it unchanged. Writing to the live status bits and to bit 5 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Ordinary asynchronous reset, active low; leaves the power-on flag alone |
| por_ni | input | 1 | Power-on reset, active low; clears everything and sets the power-on flag |
| addr_i | input | ADDR_W | Register address |
| wr_i | input | 1 | Write strobe, taken at the rising edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| tout_i | input | 1 | Periodic-timer timeout pulse, synchronous |
| lock_i | input | 1 | PLL lock status, asynchronous |
| track_i | input | 1 | PLL tracking status, asynchronous |
| scm_i | input | 1 | Self-clock mode status, asynchronous |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a collision between a write-1-to-clear and a lock or self-clock change event at the same edge. The event only shows up three edges after the input moves. The stimulus therefore changes the input, waits exactly two edges, and then issues the clearing write, so that the write lands on the edge where the change is detected. A second hard case is telling the two resets apart: the bench first clears the power-on flag, pulses the power-on input, and then pulses the ordinary reset, checking that the flag survives only the second one.

// File: rtl/cm_irq_pkg.sv
package cm_irq_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_EVT  = 3;
  localparam int NUM_STS  = 3;

  // event slot order in the sticky bank
  localparam int EVT_TOUT = 0;
  localparam int EVT_LOCK = 1;
  localparam int EVT_SCM  = 2;

  // synchronized status vector order
  localparam int STS_LOCK  = 0;
  localparam int STS_TRACK = 1;
  localparam int STS_SCM   = 2;

  // register bit positions, decoded by software
  localparam int unsigned EVT_BIT [NUM_EVT] = '{7, 4, 1};
  localparam int unsigned BIT_POR        = 6;
  localparam int unsigned BIT_LOCK_LIVE  = 3;
  localparam int unsigned BIT_TRACK_LIVE = 2;
  localparam int unsigned BIT_SCM_LIVE   = 0;

  localparam int ADDR_EN  = 0;
  localparam int ADDR_FLG = 1;

  typedef logic [REG_W-1:0] reg_t;

  function automatic reg_t en_mask();
    reg_t m;
    m = '0;
    for (int i = 0; i < NUM_EVT; i++) m[EVT_BIT[i]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/cm_sync.sv
module cm_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cm_change_det.sv
module cm_change_det #(
  parameter int WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sig_i,
  output logic [WIDTH-1:0] chg_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sig_i;
  end

  // any transition, either direction
  assign chg_o = sig_i ^ prev_q;
endmodule

// File: rtl/cm_sticky_bank.sv
module cm_sticky_bank #(
  parameter int N = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[i] <= 1'b0;
      else         q[i] <= set_i[i] | (q[i] & ~clr_i[i]);  // set beats clear
    end
  end

  assign q_o = q;
endmodule

// File: rtl/cm_irq_ctrl.sv
module cm_irq_ctrl
  import cm_irq_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              tout_i,
  input  logic              lock_i,
  input  logic              track_i,
  input  logic              scm_i,
  output logic              irq_o
);
  localparam reg_t EN_MASK = en_mask();

  logic               rst_all_n;
  logic [NUM_STS-1:0] sts_raw, sts_s;
  logic [1:0]         chg;
  logic [NUM_EVT-1:0] evt_set, evt_clr, evt_q, en_q;
  logic               por_q;
  logic               wr_en, wr_flg;
  logic               lock_live, track_live, scm_live;
  reg_t               en_rd, flg_rd;

  // power-on also acts as a full reset for all but the power-on flag
  assign rst_all_n = rst_ni & por_ni;

  assign wr_en  = wr_i && (addr_i == ADDR_W'(ADDR_EN));
  assign wr_flg = wr_i && (addr_i == ADDR_W'(ADDR_FLG));

  assign sts_raw[STS_LOCK]  = lock_i;
  assign sts_raw[STS_TRACK] = track_i;
  assign sts_raw[STS_SCM]   = scm_i;

  cm_sync #(.WIDTH(NUM_STS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_all_n),
    .d_i    (sts_raw),
    .q_o    (sts_s)
  );

  cm_change_det #(.WIDTH(2)) i_chg (
    .clk_i  (clk_i),
    .rst_ni (rst_all_n),
    .sig_i  ({sts_s[STS_SCM], sts_s[STS_LOCK]}),
    .chg_o  (chg)
  );

  assign evt_set[EVT_TOUT] = tout_i;
  assign evt_set[EVT_LOCK] = chg[0];
  assign evt_set[EVT_SCM]  = chg[1];

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_clr
    assign evt_clr[i] = wr_flg & wdata_i[EVT_BIT[i]];
  end

  cm_sticky_bank #(.N(NUM_EVT)) i_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_all_n),
    .set_i  (evt_set),
    .clr_i  (evt_clr),
    .q_o    (evt_q)
  );

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_en
    always_ff @(posedge clk_i or negedge rst_all_n) begin
      if (!rst_all_n)  en_q[i] <= 1'b0;
      else if (wr_en)  en_q[i] <= wdata_i[EVT_BIT[i]];
    end
  end

  // survives the ordinary reset
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)                        por_q <= 1'b1;
    else if (wr_flg && wdata_i[BIT_POR]) por_q <= 1'b0;
  end

  assign scm_live   = sts_s[STS_SCM];
  assign lock_live  = sts_s[STS_LOCK]  & ~scm_live;
  assign track_live = sts_s[STS_TRACK] & ~scm_live;

  always_comb begin
    en_rd  = '0;
    flg_rd = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      en_rd[EVT_BIT[i]]  = en_q[i];
      flg_rd[EVT_BIT[i]] = evt_q[i];
    end
    en_rd                  = en_rd & EN_MASK;
    flg_rd[BIT_POR]        = por_q;
    flg_rd[BIT_LOCK_LIVE]  = lock_live;
    flg_rd[BIT_TRACK_LIVE] = track_live;
    flg_rd[BIT_SCM_LIVE]   = scm_live;
  end

  always_comb begin
    if (addr_i == ADDR_W'(ADDR_EN))       rdata_o = en_rd;
    else if (addr_i == ADDR_W'(ADDR_FLG)) rdata_o = flg_rd;
    else                                  rdata_o = '0;
  end

  assign irq_o = |(evt_q & en_q);
endmodule

// File: rtl/cm_irq_ctrl_chk.sv
module cm_irq_ctrl_chk
  import cm_irq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               por_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               wr_i,
  input logic [REG_W-1:0]   wdata_i,
  input logic [REG_W-1:0]   rdata_o,
  input logic               tout_i,
  input logic               irq_o,
  input logic [NUM_EVT-1:0] evt_q,
  input logic [NUM_EVT-1:0] en_q,
  input logic               por_q,
  input logic [NUM_STS-1:0] sts_s
);
  localparam reg_t EN_MASK = en_mask();

  logic flg_wr;
  assign flg_wr = wr_i && (addr_i == ADDR_W'(ADDR_FLG));

  p_en_unused_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (addr_i == ADDR_W'(ADDR_EN)) |-> ((rdata_o & ~EN_MASK) == '0));

  p_bit5_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (addr_i == ADDR_W'(ADDR_FLG)) |-> !rdata_o[5]);

  p_tout_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    tout_i |=> evt_q[EVT_TOUT]);

  p_tout_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (flg_wr && wdata_i[EVT_BIT[EVT_TOUT]] && !tout_i) |=> !evt_q[EVT_TOUT]);

  p_por_keep_r4: assert property (@(posedge clk_i) disable iff (!por_ni)
    (por_q && !(flg_wr && wdata_i[BIT_POR])) |=> por_q);

  p_live_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (sts_s[STS_SCM] && addr_i == ADDR_W'(ADDR_FLG)) |-> (rdata_o[3:2] == 2'b00));

  p_irq_needs_pair_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    irq_o |-> ((evt_q & en_q) != '0));

  p_irq_no_por_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    ((evt_q & en_q) == '0) |-> !irq_o);

  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (tout_i && flg_wr && wdata_i[EVT_BIT[EVT_TOUT]]) |=> evt_q[EVT_TOUT]);

  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (evt_q[EVT_TOUT] && !(flg_wr && wdata_i[EVT_BIT[EVT_TOUT]])) |=> evt_q[EVT_TOUT]);
endmodule

bind cm_irq_ctrl cm_irq_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .por_ni  (por_ni),
  .addr_i  (addr_i),
  .wr_i    (wr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .tout_i  (tout_i),
  .irq_o   (irq_o),
  .evt_q   (evt_q),
  .en_q    (en_q),
  .por_q   (por_q),
  .sts_s   (sts_s)
);

// File: tb/test_cm_irq_ctrl.sv
`timescale 1ns/1ps
module test_cm_irq_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       por_ni = 1'b0;
  logic [1:0] addr_i = 2'd1;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       tout_i = 1'b0;
  logic       lock_i = 1'b0;
  logic       track_i = 1'b0;
  logic       scm_i = 1'b0;
  logic       irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  cm_irq_ctrl i_cm_irq_ctrl (
    .clk_i, .rst_ni, .por_ni, .addr_i, .wr_i, .wdata_i, .rdata_o,
    .tout_i, .lock_i, .track_i, .scm_i, .irq_o
  );

  // behavioural reference model
  bit [7:0] m_en;
  bit m_tout, m_por, m_lch, m_sch;
  bit ql[$] = '{0, 0, 0};
  bit qt[$] = '{0, 0, 0};
  bit qs[$] = '{0, 0, 0};

  task automatic model_clear();
    m_en = 0; m_tout = 0; m_lch = 0; m_sch = 0;
    ql = '{0, 0, 0}; qt = '{0, 0, 0}; qs = '{0, 0, 0};
  endtask

  always @(posedge clk_i) begin
    bit [7:0] clr;
    bit lev, sev;
    if (!por_ni) begin
      m_por = 1;
      model_clear();
    end else if (!rst_ni) begin
      model_clear();
    end else begin
      lev = ql[1] != ql[2];
      sev = qs[1] != qs[2];
      clr = (wr_i && addr_i == 2'd1) ? wdata_i : 8'h00;
      m_tout = tout_i | (m_tout & !clr[7]);
      m_por  = m_por & !clr[6];
      m_lch  = lev | (m_lch & !clr[4]);
      m_sch  = sev | (m_sch & !clr[1]);
      if (wr_i && addr_i == 2'd0) m_en = wdata_i & 8'h92;
      ql.push_front(lock_i);  void'(ql.pop_back());
      qt.push_front(track_i); void'(qt.pop_back());
      qs.push_front(scm_i);   void'(qs.pop_back());
    end
  end

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic compare();
    bit live_scm, live_lock, live_trk, exp_irq;
    live_scm  = qs[1];
    live_lock = ql[1] & !live_scm;
    live_trk  = qt[1] & !live_scm;
    exp_irq = (m_tout & m_en[7]) | (m_lch & m_en[4]) | (m_sch & m_en[1]);
    chk("R8 irq", irq_o, exp_irq);
    case (addr_i)
      2'd0: chk("R1 enable reg", rdata_o, m_en);
      2'd1: begin
        chk("R3 timeout flag", rdata_o[7], m_tout);
        chk("R4 power-on flag", rdata_o[6], m_por);
        chk("R2 bit5", rdata_o[5], 0);
        chk("R5 lock-change flag", rdata_o[4], m_lch);
        chk("R7 live lock", rdata_o[3], live_lock);
        chk("R7 live track", rdata_o[2], live_trk);
        chk("R6 scm-change flag", rdata_o[1], m_sch);
        chk("R7 live scm", rdata_o[0], live_scm);
      end
      default: chk("R2 unmapped read", rdata_o, 0);
    endcase
  endtask

  task automatic tick(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      compare();
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    logic [1:0] keep;
    keep = addr_i;
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    tick(1);
    wr_i = 1'b0; addr_i = keep;
  endtask

  task automatic peek(string req, logic [1:0] a, int exp);
    addr_i = a;
    #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    por_ni = 1'b1; rst_ni = 1'b1;
    tick(1);
    peek("R4 reset state flags", 2'd1, 8'h40);
    peek("R1 reset state enables", 2'd0, 8'h00);
    addr_i = 2'd1;
    wr(2'd1, 8'h40);
    peek("R4 power-on flag w1c", 2'd1, 8'h00);
    wr(2'd0, 8'hFF);
    peek("R1 enable unused bits", 2'd0, 8'h92);
    addr_i = 2'd1;

    tout_i = 1'b1; tick(1); tout_i = 1'b0;
    chk("R3 timeout sets", rdata_o[7], 1);
    chk("R8 irq from timeout", irq_o, 1);
    wr(2'd1, 8'h00);
    chk("R10 write 0 keeps flag", rdata_o[7], 1);
    wr(2'd1, 8'h80);
    chk("R3 timeout w1c", rdata_o[7], 0);
    chk("R8 irq drops", irq_o, 0);

    lock_i = 1'b1; tick(2);
    chk("R7 live lock after 2 edges", rdata_o[3], 1);
    chk("R5 lock flag not yet", rdata_o[4], 0);
    tick(1);
    chk("R5 lock rise flag", rdata_o[4], 1);
    wr(2'd1, 8'h10);
    lock_i = 1'b0; tick(3);
    chk("R5 lock fall flag", rdata_o[4], 1);
    wr(2'd1, 8'h10);

    lock_i = 1'b1; track_i = 1'b1; tick(5);
    wr(2'd1, 8'h10);
    peek("R7 live lock and track", 2'd1, 8'h0C);
    wr(2'd1, 8'h0D);
    peek("R10 live bits ignore writes", 2'd1, 8'h0C);
    scm_i = 1'b1; tick(2);
    chk("R7 masked by scm", rdata_o[3:0], 4'h1);
    tick(1);
    chk("R6 scm rise flag", rdata_o[1], 1);
    wr(2'd1, 8'h02);
    scm_i = 1'b0; tick(3);
    chk("R6 scm fall flag", rdata_o[1], 1);
    chk("R7 unmasked again", rdata_o[3:2], 2'b11);
    wr(2'd1, 8'h02);

    lock_i = 1'b0; tick(2);
    wr(2'd1, 8'h10);
    chk("R9 lock set beats clear", rdata_o[4], 1);
    tout_i = 1'b1;
    wr(2'd1, 8'h80);
    tout_i = 1'b0;
    chk("R9 timeout set beats clear", rdata_o[7], 1);

    wr(2'd0, 8'h00);
    chk("R8 no irq when disabled", irq_o, 0);
    wr(2'd0, 8'h10);
    chk("R8 lock pair irq", irq_o, 1);
    wr(2'd0, 8'h00);

    wr(2'd2, 8'hFF);
    wr(2'd3, 8'hFF);
    peek("R2 unmapped reads 0", 2'd2, 8'h00);
    peek("R2 unmapped write no effect", 2'd0, 8'h00);
    addr_i = 2'd1;

    track_i = 1'b0; tick(3);
    wr(2'd1, 8'hFF);
    peek("R10 all cleared", 2'd1, 8'h00);
    por_ni = 1'b0; tick(2); por_ni = 1'b1; tick(1);
    peek("R4 power-on sets flag", 2'd1, 8'h40);
    wr(2'd0, 8'hFF);
    chk("R8 power-on flag no irq", irq_o, 0);
    rst_ni = 1'b0; tick(2); rst_ni = 1'b1; tick(1);
    peek("R4 flag survives reset", 2'd1, 8'h40);
    peek("R1 reset clears enables", 2'd0, 8'h00);
    addr_i = 2'd1;
    tick(4);

    done = 1;
    summary();
    $finish;
  end
endmodule